// File: doc/BRIEF.md
# Loadable Modulo Sequencer

This block is a 4-bit synchronous up-counter that produces shortened count sequences. When the count reaches the last value of the selected sequence, the block reloads a start value on the next clock edge. It never uses an asynchronous clear, so no value is cut short and no transient state appears on the output. A select input picks one of two sequences. With `mode_nine` low, the block counts 0 to 6 and then returns to 0, which is a modulo-7 sequence. With `mode_nine` high, it starts from 9, counts up to 14 and then returns to 9, which is a modulo-6 sequence placed at an offset.

The terminal value is found with a partial decode. Only the bits that are 1 in the last value are tested, and every value outside the legal range is treated as don't-care. A parallel load port can place any value into the counter, legal or not. From any value, the decode brings the counter back into its legal sequence within one binary wrap. The block also drives a terminal flag and a carry out. The carry out is built in and goes high when an enabled count sits at 15.

Top module: `mod_seq_counter`

## Requirements
- R1: When `rst` is high at a clock edge, the count becomes 0 if `mode_nine` is 0 and 9 if `mode_nine` is 1. Reset has priority over every other input.
- R2: In modulo-7 mode (`mode_nine`=0), an enabled count of 6 is followed by 0. This gives the sequence 0,1,2,3,4,5,6,0.
- R3: In modulo-7 mode, an enabled count of 0 to 5 advances by one at each edge.
- R4: In modulo-6 mode (`mode_nine`=1), an enabled count of 14 is followed by 9, and enabled counts of 9 to 13 advance by one. This gives the sequence 9,10,11,12,13,14,9.
- R5: With `cnt_en` low and `ld` low, the count holds its value.
- R6: When `ld` is high and `rst` is low, the next count is `ld_val`. This holds whatever `cnt_en` is and whether or not the count is at its terminal value.
- R7: `term` is high exactly when the count equals the last legal value of the selected mode: 6 in modulo-7 mode and 14 in modulo-6 mode.
- R8: `carry` is high exactly when the count is 15 and `cnt_en` is high.
- R9: Illegal values recover as follows. In modulo-7 mode, any enabled count whose bits 2 and 1 are both 1 (6, 7, 14 or 15) reloads 0. In modulo-6 mode, an enabled 14 or 15 reloads 9. Every other enabled value adds one, and 15 wraps to 0. As a result, any start value reaches the legal sequence within 16 enabled edges.
- R10: After a reset, as long as `ld` stays low and the mode is not changed, the count only ever shows values from the legal set of the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the mode's start value |
| mode_nine | input | 1 | 0: modulo-7 sequence 0..6; 1: modulo-6 sequence 9..14 |
| cnt_en | input | 1 | Count enable |
| ld | input | 1 | Synchronous parallel load strobe |
| ld_val | input | 4 | Value written on load |
| count | output | 4 | Current count |
| term | output | 1 | High on the last value of the selected sequence |
| carry | output | 1 | High when the count is 15 and counting is enabled |

## Verification
Two functions can act in the same cycle: a parallel load can arrive at the edge where the terminal reload would fire. The bench provokes this on purpose. It first runs the counter up to 6 or 14 with the enable high and then raises `ld`. It also raises `rst` and `ld` together. A cycle-accurate behavioural model gives load priority over the reload and gives reset priority over both. The count, `term` and `carry` are compared with that model at every cycle.

// File: rtl/mod_seq_counter.sv
module mod_seq_counter #(
  parameter int W = 4,
  parameter logic [W-1:0] BASE_A = 4'd0,
  parameter logic [W-1:0] LAST_A = 4'd6,
  parameter logic [W-1:0] BASE_B = 4'd9,
  parameter logic [W-1:0] LAST_B = 4'd14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_nine,
  input  logic         cnt_en,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] count,
  output logic         term,
  output logic         carry
);

  logic [W-1:0] q;
  logic [W-1:0] base;
  logic [W-1:0] last;
  logic         hit;

  assign base = mode_nine ? BASE_B : BASE_A;
  assign last = mode_nine ? LAST_B : LAST_A;

  // partial decode: only the bits set in the last value are tested
  assign hit = &(q | ~last);

  always_ff @(posedge clk) begin
    if (rst)
      q <= base;
    else if (ld)
      q <= ld_val;
    else if (cnt_en)
      q <= hit ? base : q + 1'b1;
  end

  assign count = q;
  assign term  = (q == last);
  assign carry = (&q) & cnt_en;

  a_r1_reset_start: assert property (@(posedge clk)
    rst |=> (count == ($past(mode_nine) ? BASE_B : BASE_A)));

  a_r2_m7_reload: assert property (@(posedge clk) disable iff (rst)
    (!mode_nine && cnt_en && !ld && count == LAST_A) |=> count == BASE_A);

  a_r3_m7_step: assert property (@(posedge clk) disable iff (rst)
    (!mode_nine && cnt_en && !ld && count < LAST_A) |=> count == $past(count) + 1'b1);

  a_r4_m6_reload: assert property (@(posedge clk) disable iff (rst)
    (mode_nine && cnt_en && !ld && count == LAST_B) |=> count == BASE_B);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !ld) |=> $stable(count));

  a_r6_load_wins: assert property (@(posedge clk) disable iff (rst)
    ld |=> count == $past(ld_val));

  a_r7_term_reload: assert property (@(posedge clk) disable iff (rst)
    (term && cnt_en && !ld) |=> count == ($past(mode_nine) ? BASE_B : BASE_A));

  a_r8_carry_exit: assert property (@(posedge clk) disable iff (rst)
    (carry && !ld) |=> count == ($past(mode_nine) ? BASE_B : BASE_A));

  a_r9_m7_seven: assert property (@(posedge clk) disable iff (rst)
    (!mode_nine && cnt_en && !ld && count == 4'd7) |=> count == BASE_A);

endmodule

// File: tb/tb_mod_seq_counter.sv
module tb_mod_seq_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_nine = 1'b0;
  logic       cnt_en = 1'b0;
  logic       ld = 1'b0;
  logic [3:0] ld_val = 4'd0;
  logic [3:0] count;
  logic       term;
  logic       carry;

  int    errors = 0;
  int    checks = 0;
  int    m = 0;
  bit    legal_run = 1'b0;
  bit    done = 1'b0;
  string req = "R1";

  mod_seq_counter dut (
    .clk(clk), .rst(rst), .mode_nine(mode_nine), .cnt_en(cnt_en),
    .ld(ld), .ld_val(ld_val), .count(count), .term(term), .carry(carry)
  );

  always #10 clk = ~clk;

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) begin
      m = mode_nine ? 9 : 0;
      legal_run = 1'b1;
    end else if (ld) begin
      m = ld_val;
      legal_run = 1'b0;
    end else if (cnt_en) begin
      if (mode_nine) m = (m >= 14) ? 9 : (m + 1) % 16;
      else           m = (m % 8 >= 6) ? 0 : (m + 1) % 16;
    end
    @(negedge clk);
    check(req, count, m);
    check("R7", term, mode_nine ? (m == 14) : (m == 6));
    check("R8", carry, (m == 15) && cnt_en);
    if (legal_run)
      check("R10", mode_nine ? (count >= 9 && count <= 14) : (count <= 6), 1);
  endtask

  task automatic drive(bit r, bit s, bit e, bit l, int v);
    rst = r; mode_nine = s; cnt_en = e; ld = l; ld_val = 4'(v);
  endtask

  initial begin
    @(negedge clk);
    req = "R1";
    drive(1, 0, 0, 0, 0); step();
    check("R1", count, 0);
    req = "R3";
    drive(0, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) step();
    req = "R2";
    for (int i = 0; i < 30; i++) step();
    req = "R5";
    for (int i = 0; i < 40; i++) begin
      cnt_en = 1'($urandom_range(0, 1));
      step();
    end
    req = "R1";
    drive(1, 1, 0, 0, 0); step();
    check("R1", count, 9);
    req = "R4";
    drive(0, 1, 1, 0, 0);
    for (int i = 0; i < 30; i++) step();
    req = "R8";
    drive(0, 1, 1, 1, 15); step();
    drive(0, 1, 1, 0, 0);  step();
    req = "R9";
    drive(0, 1, 1, 1, 0); step();
    drive(0, 1, 1, 0, 0);
    for (int i = 0; i < 18; i++) step();
    drive(0, 0, 1, 1, 7); step();
    drive(0, 0, 1, 0, 0); step();
    check("R9", count, 0);
    drive(0, 0, 1, 1, 14); step();
    drive(0, 0, 1, 0, 0); step();
    check("R9", count, 0);
    drive(0, 0, 1, 1, 8);  step();
    drive(0, 0, 1, 0, 0);
    for (int i = 0; i < 12; i++) step();
    req = "R6";
    drive(1, 0, 0, 0, 0); step();
    drive(0, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) step();
    drive(0, 0, 1, 1, 11); step();
    check("R6", count, 11);
    drive(1, 1, 0, 0, 0); step();
    drive(0, 1, 1, 0, 0);
    for (int i = 0; i < 5; i++) step();
    drive(0, 1, 1, 1, 3); step();
    check("R6", count, 3);
    drive(1, 0, 1, 1, 12); step();
    check("R6", count, 0);
    for (int i = 0; i < 300; i++) begin
      drive(($urandom_range(0, 40) == 0), 1'($urandom_range(0, 1) & (i / 50 % 2)),
            1'($urandom_range(0, 3) != 0), ($urandom_range(0, 9) == 0), $urandom_range(0, 15));
      if (i % 50 == 0) begin
        mode_nine = ~mode_nine;
        legal_run = 1'b0;
      end
      step();
      if (rst == 1'b0 && mode_nine != mode_nine) legal_run = 1'b0;
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  bit prev_mode = 1'b0;
  always @(negedge clk) begin
    if (mode_nine != prev_mode) legal_run = 1'b0;
    prev_mode = mode_nine;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule